// File: doc/BRIEF.md
# Qualified Sample Storage Gate

This block sits between the acquisition front end and the acquisition memory. For every valid sample it decides whether the sample is written to memory. It outputs the sample stream delayed by a fixed number of valid samples, together with a store strobe that qualifies each delayed sample. The delay means a sample can still be written after the block learns that a later sample qualified.

A sample qualifies under one of three rules. When qualification is disabled, every sample qualifies. When a state command is present, the command decides. Otherwise a sticky storage flag is ANDed with the global condition result. State commands overwrite the flag for later samples. An acquisition start loads the flag with the configured start value, and reset leaves the flag set.

The block has two storage modes. In event mode only qualified samples are stored. In block mode each qualified sample is stored together with a window around it: `LEAD_N` samples before it and `TAIL_N` samples after it, 31 each by default. Windows that overlap merge, so each sample is still emitted exactly once. Block mode falls back to event mode when qualification is disabled or when violation storage is enabled.

Top module: `storage_qualifier`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `outValid` and `outStore` are 0.
- R2: Every valid input sample leaves on `outData` unchanged and in order. It leaves with `outValid` high on the clock edge that accepts the `LEAD_N`-th later valid sample, so the output is registered one cycle after that sample is presented.
- R3: A cycle with `sampleValid` low neither advances the delay line nor changes any qualification state. Its `globalHit`, `cmdValid` and `cmdOn` are ignored. In the following cycle `outValid` is 0 and `outData` holds its value.
- R4: With `qualEnable` = 0, every emitted sample has `outStore` = 1.
- R5: With `qualEnable` = 1 and `cmdValid` = 0, a sample qualifies exactly when `globalHit` = 1 and the storage flag is set.
- R6: With `qualEnable` = 1 and `cmdValid` = 1, a sample qualifies exactly when `cmdOn` = 1, whatever `globalHit` is. The storage flag then takes the value of `cmdOn`.
- R7: Reset sets the storage flag. An `acqStart` pulse loads the flag from `startStoreOn`.
- R8: In event mode (`blockMode` = 0), an emitted sample is stored exactly when it qualified.
- R9: In block mode, an emitted sample k is stored exactly when some sample j of the current acquisition with k-`TAIL_N` <= j <= k+`LEAD_N` qualified. Overlapping windows store each sample once.
- R10: With `violStoreEn` = 1, block mode behaves as event mode.
- R11: With `qualEnable` = 0, `blockMode` has no effect.
- R12: The `acqStart` cycle drops any sample presented with it. It clears the delay fill and the after-window count, so the next `LEAD_N` valid samples produce no output and no sample from before the start is ever emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acqStart | input | 1 | Pulse that begins a new acquisition |
| sampleValid | input | 1 | Sample strobe for this cycle |
| sampleData | input | DATA_W | Acquired sample |
| globalHit | input | 1 | Result of the global storage condition |
| cmdValid | input | 1 | Current trigger state issues a storage command |
| cmdOn | input | 1 | Command value: 1 store, 0 do not store |
| qualEnable | input | 1 | Storage qualification in use |
| blockMode | input | 1 | Request block (windowed) storage |
| violStoreEn | input | 1 | Violation storage enabled (forbids block mode) |
| startStoreOn | input | 1 | Storage flag value loaded at acquisition start |
| outValid | output | 1 | Delayed sample present on outData |
| outStore | output | 1 | Write the delayed sample to memory |
| outData | output | DATA_W | Delayed sample |

## Verification
The bench interleaves idle cycles that carry a hit and an "off" command. A design that let invalid cycles move the window or the flag would misalign the data or lose stored samples later in the stream. Block mode is run with isolated hits, including a hit on the very first sample. This exposes off-by-one window edges, a missing after-window, or leakage from before the acquisition start. Commands that contradict the global hit show whether the override and the sticky flag are honoured. A configuration with violation storage enabled catches a design that still widens the window. Each acquisition tags its data with its own number, so any leftover sample emitted after a restart fails the data comparison.

// File: rtl/sq_pkg.sv
package sq_pkg;

  // Strobes the control half hands to the datapath every cycle
  typedef struct packed {
    logic shift;       // accept the incoming sample into the delay line
    logic qualNew;     // qualification of the incoming sample
    logic emit;        // oldest stage leaves this cycle
    logic blockMode;   // effective block mode after the fallbacks
    logic postActive;  // after-window of an earlier qualified sample still open
  } ctrl_strobe_t;

endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int LEAD_N = 31,
  parameter int TAIL_N = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acqStart,
  input  logic         sampleValid,
  input  logic         globalHit,
  input  logic         cmdValid,
  input  logic         cmdOn,
  input  logic         qualEnable,
  input  logic         blockMode,
  input  logic         violStoreEn,
  input  logic         startStoreOn,
  input  logic         oldestQual,
  output ctrl_strobe_t strobe
);

  localparam int FILL_W = $clog2(LEAD_N + 1);
  localparam int TAIL_W = $clog2(TAIL_N + 1);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(LEAD_N);
  localparam logic [TAIL_W-1:0] TAIL_LOAD = TAIL_W'(TAIL_N);

  logic              storeOn;
  logic [FILL_W-1:0] fillCnt;
  logic [TAIL_W-1:0] postCnt;
  logic              accept;
  logic              filled;
  logic              qualNow;

  assign accept = sampleValid && !acqStart;
  assign filled = (fillCnt == FILL_FULL);

  // Per-sample qualification: state command beats the global rule
  always_comb begin
    if (!qualEnable)   qualNow = 1'b1;
    else if (cmdValid) qualNow = cmdOn;
    else               qualNow = storeOn && globalHit;
  end

  // Sticky storage flag
  always_ff @(posedge clk) begin
    if (!rst_n)                                storeOn <= 1'b1;
    else if (acqStart)                         storeOn <= startStoreOn;
    else if (accept && qualEnable && cmdValid) storeOn <= cmdOn;
  end

  // Delay-line fill tracking, counted in valid samples only
  always_ff @(posedge clk) begin
    if (!rst_n || acqStart)     fillCnt <= '0;
    else if (accept && !filled) fillCnt <= fillCnt + 1'b1;
  end

  // After-window counter, advanced per emitted sample
  always_ff @(posedge clk) begin
    if (!rst_n || acqStart) postCnt <= '0;
    else if (accept && filled) begin
      if (oldestQual)          postCnt <= TAIL_LOAD;
      else if (postCnt != '0)  postCnt <= postCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.shift      = accept;
    strobe.qualNew    = qualNow;
    strobe.emit       = accept && filled;
    strobe.blockMode  = blockMode && qualEnable && !violStoreEn;
    strobe.postActive = (postCnt != '0);
  end

endmodule

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEAD_N = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strobe_t      strobe,
  input  logic [DATA_W-1:0] sampleData,
  output logic              oldestQual,
  output logic              outValid,
  output logic              outStore,
  output logic [DATA_W-1:0] outData
);

  logic [DATA_W-1:0] dataLine [LEAD_N];
  logic [LEAD_N-1:0] qualLine;
  logic              laterHit;
  logic              keep;

  // Stage 0 takes the new sample; stage g takes stage g-1
  for (genvar g = 0; g < LEAD_N; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)            qualLine[0] <= 1'b0;
        else if (strobe.shift) qualLine[0] <= strobe.qualNew;
      end
      always_ff @(posedge clk) begin
        if (strobe.shift) dataLine[0] <= sampleData;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)            qualLine[g] <= 1'b0;
        else if (strobe.shift) qualLine[g] <= qualLine[g-1];
      end
      always_ff @(posedge clk) begin
        if (strobe.shift) dataLine[g] <= dataLine[g-1];
      end
    end
  end

  assign oldestQual = qualLine[LEAD_N-1];

  // Any qualified sample among those that follow the oldest one
  always_comb begin
    laterHit = strobe.qualNew;
    for (int s = 0; s < LEAD_N - 1; s++) laterHit = laterHit | qualLine[s];
  end

  assign keep = oldestQual ||
                (strobe.blockMode && (laterHit || strobe.postActive));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outStore <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.emit;
      outStore <= strobe.emit && keep;
      if (strobe.emit) outData <= dataLine[LEAD_N-1];
    end
  end

endmodule

// File: rtl/storage_qualifier.sv
module storage_qualifier
  import sq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEAD_N = 31,
  parameter int TAIL_N = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acqStart,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              globalHit,
  input  logic              cmdValid,
  input  logic              cmdOn,
  input  logic              qualEnable,
  input  logic              blockMode,
  input  logic              violStoreEn,
  input  logic              startStoreOn,
  output logic              outValid,
  output logic              outStore,
  output logic [DATA_W-1:0] outData
);

  ctrl_strobe_t strobe;
  logic         oldestQual;

  sq_ctrl #(.LEAD_N(LEAD_N), .TAIL_N(TAIL_N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acqStart(acqStart), .sampleValid(sampleValid),
    .globalHit(globalHit), .cmdValid(cmdValid), .cmdOn(cmdOn),
    .qualEnable(qualEnable), .blockMode(blockMode), .violStoreEn(violStoreEn),
    .startStoreOn(startStoreOn), .oldestQual(oldestQual), .strobe(strobe)
  );

  sq_datapath #(.DATA_W(DATA_W), .LEAD_N(LEAD_N)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sampleData(sampleData),
    .oldestQual(oldestQual), .outValid(outValid), .outStore(outStore),
    .outData(outData)
  );

endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acqStart,
  input logic              sampleValid,
  input logic              outValid,
  input logic              outStore,
  input logic [DATA_W-1:0] outData
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!outValid && !outStore));

  p_store_needs_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    outStore |-> outValid);

  p_idle_no_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> !outValid);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(outData));

  p_restart_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acqStart |=> !outValid);

endmodule

bind storage_qualifier sq_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acqStart(acqStart), .sampleValid(sampleValid),
  .outValid(outValid), .outStore(outStore), .outData(outData)
);

// File: tb/storage_qualifier_test.sv
`timescale 1ns/1ps
module storage_qualifier_test;

  localparam int DATA_W = 16;
  localparam int LEAD_N = 31;
  localparam int TAIL_N = 31;
  localparam int NSAMP  = 180;
  localparam int NSCEN  = 8;

  // {doStart, qualEn, block, viol, startOn, pattern[1:0]}
  localparam logic [6:0] SCEN [NSCEN] = '{
    7'b0_1_0_0_1_00,  // after reset, no start: flag defaults on (R7), event (R8)
    7'b1_0_1_0_0_00,  // qualification off: all stored, block ignored (R4, R11)
    7'b1_1_0_0_1_00,  // event mode, global rule (R5, R8)
    7'b1_1_1_0_1_00,  // block mode, overlapping windows (R9)
    7'b1_1_1_1_1_00,  // block requested with violation storage (R10)
    7'b1_1_0_0_0_01,  // start off, commands override (R6, R7)
    7'b1_1_1_0_1_10,  // block mode, isolated and edge hits (R9)
    7'b1_1_1_0_0_01   // block mode driven by commands (R6, R9)
  };

  logic clk = 1'b0;
  logic rst_n;
  logic acqStart, sampleValid, globalHit, cmdValid, cmdOn;
  logic qualEnable, blockMode, violStoreEn, startStoreOn;
  logic [DATA_W-1:0] sampleData;
  logic outValid, outStore;
  logic [DATA_W-1:0] outData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic qualArr [NSAMP];
  logic cfgQual, cfgBlock, cfgViol;
  logic [DATA_W-1:0] lastData;

  always #2 clk = ~clk;

  storage_qualifier #(.DATA_W(DATA_W), .LEAD_N(LEAD_N), .TAIL_N(TAIL_N)) uut (
    .clk(clk), .rst_n(rst_n), .acqStart(acqStart), .sampleValid(sampleValid),
    .sampleData(sampleData), .globalHit(globalHit), .cmdValid(cmdValid),
    .cmdOn(cmdOn), .qualEnable(qualEnable), .blockMode(blockMode),
    .violStoreEn(violStoreEn), .startStoreOn(startStoreOn),
    .outValid(outValid), .outStore(outStore), .outData(outData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 200000) begin
      $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 200000);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
    end
  end

  function automatic logic patHit(input logic [1:0] p, input int i);
    case (p)
      2'd0:    return (i % 17) == 3;
      2'd1:    return (i % 5) == 0;
      default: return (i == 0) || (i == 100);
    endcase
  endfunction

  function automatic logic patCmdV(input logic [1:0] p, input int i);
    return (p == 2'd1) && (i == 40 || i == 81 || i == 100 || i == 123);
  endfunction

  function automatic logic patCmdO(input int i);
    return (i == 40) || (i == 123);
  endfunction

  function automatic logic expStore(input int k);
    logic hit;
    if (!cfgQual) return 1'b1;
    if (!(cfgBlock && !cfgViol)) return qualArr[k];
    hit = 1'b0;
    for (int j = k - TAIL_N; j <= k + LEAD_N; j++)
      if (j >= 0 && j < NSAMP && qualArr[j]) hit = 1'b1;
    return hit;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance one cycle with inputs already driven, then look at the result
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runScen(input int sc);
    logic [6:0] cfg = SCEN[sc];
    logic flag;
    int sent = 0;
    cfgQual  = cfg[5];
    cfgBlock = cfg[4];
    cfgViol  = cfg[3];
    qualEnable = cfg[5]; blockMode = cfg[4]; violStoreEn = cfg[3]; startStoreOn = cfg[2];
    // independent qualification model
    flag = cfg[6] ? cfg[2] : 1'b1;
    for (int i = 0; i < NSAMP; i++) begin
      if (!cfg[5]) qualArr[i] = 1'b1;
      else if (patCmdV(cfg[1:0], i)) begin
        qualArr[i] = patCmdO(i);
        flag = patCmdO(i);
      end else qualArr[i] = flag && patHit(cfg[1:0], i);
    end
    if (cfg[6]) begin
      acqStart = 1'b1; sampleValid = 1'b1; sampleData = 16'hDEAD;
      step();
      check("R12 start cycle outValid", {31'b0, outValid}, 32'd0);
      acqStart = 1'b0;
    end
    for (int i = 0; i < NSAMP; i++) begin
      sampleValid = 1'b1;
      sampleData  = DATA_W'((sc << 8) | i);
      globalHit   = patHit(cfg[1:0], i);
      cmdValid    = patCmdV(cfg[1:0], i);
      cmdOn       = patCmdO(i);
      step();
      if (sent >= LEAD_N) begin
        check("R2 outValid", {31'b0, outValid}, 32'd1);
        check("R2 outData", {16'b0, outData}, (sc << 8) | (sent - LEAD_N));
        check("R4/R5/R6/R8/R9/R10/R11 outStore", {31'b0, outStore},
              {31'b0, expStore(sent - LEAD_N)});
      end else begin
        check("R12 no emission during fill", {31'b0, outValid}, 32'd0);
      end
      sent++;
      lastData = outData;
      if ((i % 7) == 6) begin
        // idle cycle carrying noise that must be ignored (R3)
        sampleValid = 1'b0; globalHit = 1'b1; cmdValid = 1'b1; cmdOn = 1'b0;
        sampleData = 16'hBEEF;
        step();
        check("R3 idle outValid", {31'b0, outValid}, 32'd0);
        check("R3 idle outData held", {16'b0, outData}, {16'b0, lastData});
      end
    end
    sampleValid = 1'b0; globalHit = 1'b0; cmdValid = 1'b0; cmdOn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    acqStart = 1'b0; sampleValid = 1'b0; sampleData = '0;
    globalHit = 1'b0; cmdValid = 1'b0; cmdOn = 1'b0;
    qualEnable = 1'b0; blockMode = 1'b0; violStoreEn = 1'b0; startStoreOn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset outValid", {31'b0, outValid}, 32'd0);
    check("R1 reset outStore", {31'b0, outStore}, 32'd0);
    rst_n = 1'b1;
    step();
    check("R1 after reset outValid", {31'b0, outValid}, 32'd0);
    for (int sc = 0; sc < NSCEN; sc++) runScen(sc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule